// File: doc/BRIEF.md
# GPIO Bank with Peripheral Multiplexing

This block manages a bank of 32 general-purpose pins behind a simple word-addressed register bus. For every pin, it chooses whether the GPIO logic drives the pad or one of two internal peripheral functions does. It holds each pin's output enable, output data, pull-up enable and open-drain mode. It also returns the synchronized level seen on every pad, whichever function is driving it.

Every configuration field is a 32-bit vector with one bit per pin. Software never writes such a vector directly. Each field has three addresses: a set port, a clear port and a read-only status view. A 1 in the write data sets or clears the matching pin's bit, and a 0 leaves that bit alone. Several pins can therefore be reconfigured in one write without a read-modify-write sequence.

Address layout (word addresses, `addr[5:2]` = field, `addr[1:0]` = port; port 0 = set, 1 = clear, 2 = status):

| Field | Set | Clear | Status | Meaning of a 1 bit |
|---|---|---|---|---|
| own | 0 | 1 | 2 | GPIO logic drives the pin |
| bsel | 4 | 5 | 6 | peripheral B is selected (0 selects A) |
| oe | 8 | 9 | 10 | GPIO output enable |
| dout | 12 | 13 | 14 | GPIO output data |
| pull | 16 | 17 | 18 | pull-up enabled |
| odrn | 20 | 21 | 22 | open-drain (multi-drive) mode |

The pad level view is at address 24.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset, the status views read: own = 0xFFFFFFFF, bsel = 0, oe = 0, dout = 0, pull = 0xFFFFFFFF and odrn = 0. The pad outputs show pad_oe = 0, pad_out = 0 and pad_pu = 0xFFFFFFFF.
- R2: A write to a field's set address (port 0) sets each bit whose write data bit is 1 and leaves every bit written 0 unchanged. The result is visible at the status address from the next cycle.
- R3: A write to a field's clear address (port 1) clears each bit whose write data bit is 1 and leaves every bit written 0 unchanged.
- R4: The set and clear addresses always read 0. The status address (port 2) reads the field's current vector.
- R5: When a pin's own bit is 1 and its odrn bit is 0, pad_out follows its dout bit and pad_oe follows its oe bit.
- R6: When a pin's own bit is 0 and its odrn bit is 0, the pin takes pad_out and pad_oe from peripheral A (pa_out, pa_oe) if its bsel bit is 0, and from peripheral B (pb_out, pb_oe) if its bsel bit is 1.
- R7: When a pin's odrn bit is 1, pad_out is 0 and pad_oe is 1 only if the selected source enables the output and drives 0. The pin therefore never drives high.
- R8: pad_pu equals the pull field at all times.
- R9: The level view (address 24) returns pad_in after two register stages. A pad change appears at the second rising edge after it and does not appear after only one edge. This holds whatever function drives the pin.
- R10: Writes to unmapped addresses (port 3 of any field, or addresses 25 to 63) change no field. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Word address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data (per-pin mask for set/clear ports) |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pa_out | input | 32 | Peripheral A output data per pin |
| pa_oe | input | 32 | Peripheral A output enable per pin |
| pb_out | input | 32 | Peripheral B output data per pin |
| pb_oe | input | 32 | Peripheral B output enable per pin |
| pad_in | input | 32 | Level sensed on each pad |
| pad_out | output | 32 | Data driven to each pad |
| pad_oe | output | 32 | Output enable for each pad |
| pad_pu | output | 32 | Pull-up enable for each pad |

## Verification
The set and clear ports are exercised with a walking single-bit mask on every field. This shows that each bit is independent and that zero bits are preserved, which an implementation that simply stores the write data would fail. The pad selection is swept over all 512 combinations of the ownership, select, enable, data and open-drain bits against the A and B peripheral signals. This separates the GPIO, A and B paths, and it catches an open-drain stage that drives high or that ignores the source enable. The level view is tested with changing pad patterns under GPIO and peripheral ownership, sampled one edge and two edges after the change, which pins down the synchronizer depth exactly.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants and field encodings for the GPIO bank.
// Assumes a word-addressed bus where addr[1:0] picks the port and the
// upper address bits pick the configuration field.
package gpio_bank_pkg;

    // configuration fields, each a one-bit-per-pin vector
    typedef enum logic [3:0] {
        FLD_OWN  = 4'd0,
        FLD_BSEL = 4'd1,
        FLD_OE   = 4'd2,
        FLD_DOUT = 4'd3,
        FLD_PULL = 4'd4,
        FLD_ODRN = 4'd5
    } cfg_field_e;

    localparam int unsigned NUM_FIELDS = 6;

    // port within a field
    typedef enum logic [1:0] {
        PORT_SET  = 2'd0,
        PORT_CLR  = 2'd1,
        PORT_STAT = 2'd2,
        PORT_NONE = 2'd3
    } cfg_port_e;

    // field index of the pad level view (address 24 = field 6, port 0)
    localparam logic [3:0] LEVEL_FIELD = 4'd6;

    // reset value of every bit of a field
    function automatic logic field_reset_bit(input int unsigned fld);
        return (fld == FLD_OWN) || (fld == FLD_PULL);
    endfunction

endpackage

// File: rtl/gpio_setclr_reg.sv
// Module: one configuration field held in flops and changed only through
// a write-one-to-set strobe and a write-one-to-clear strobe.
// Assumes set_we and clr_we are never high together (one bus address per cycle).
module gpio_setclr_reg #(
    parameter int unsigned WIDTH   = 32,
    parameter logic        RST_BIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] wmask,
    output logic [WIDTH-1:0] state
);

    localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_BIT}};

    // update only the masked bits on a set or clear strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RST_VEC;
        end else if (set_we) begin
            state <= state | wmask;
        end else if (clr_we) begin
            state <= state & ~wmask;
        end
    end

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((state & $past(wmask)) == $past(wmask)));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((state & $past(wmask)) == '0));

    // R2
    set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((state & ~$past(wmask)) == ($past(state) & ~$past(wmask))));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> (state == $past(state)));

endmodule

// File: rtl/gpio_pad_mux.sv
// Module: per-pin source selection for the pad drivers. GPIO logic,
// peripheral A or peripheral B is chosen, and then an optional open-drain stage
// turns a high level into a released pad.
// Assumes all inputs are already stable configuration or peripheral levels.
module gpio_pad_mux #(
    parameter int unsigned NPINS = 32
) (
    input  logic [NPINS-1:0] own,
    input  logic [NPINS-1:0] bsel,
    input  logic [NPINS-1:0] gp_oe,
    input  logic [NPINS-1:0] gp_dout,
    input  logic [NPINS-1:0] odrn,
    input  logic [NPINS-1:0] pa_out,
    input  logic [NPINS-1:0] pa_oe,
    input  logic [NPINS-1:0] pb_out,
    input  logic [NPINS-1:0] pb_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic src_d;
        logic src_e;

        // pick the driving function of this pin
        always_comb begin
            if (own[p]) begin
                src_d = gp_dout[p];
                src_e = gp_oe[p];
            end else if (bsel[p]) begin
                src_d = pb_out[p];
                src_e = pb_oe[p];
            end else begin
                src_d = pa_out[p];
                src_e = pa_oe[p];
            end
        end

        // open-drain: only pull low, release instead of driving high
        always_comb begin
            if (odrn[p]) begin
                pad_out[p] = 1'b0;
                pad_oe[p]  = src_e & ~src_d;
            end else begin
                pad_out[p] = src_d;
                pad_oe[p]  = src_e;
            end
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: multi-stage synchronizer for the pad levels.
// Assumes each pad bit is an independent level (no multi-bit coherence needed).
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // shift the pad levels through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

    // count edges since reset so the latency check only looks at valid history
    logic [1:0] primed_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_cnt <= '0;
        end else if (primed_cnt != 2'd3) begin
            primed_cnt <= primed_cnt + 2'd1;
        end
    end

    if (STAGES == 2) begin : g_two_stage_chk
        // R9
        sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (primed_cnt >= 2'd2) |-> (dout == $past(din, 2)));
    end

endmodule

// File: rtl/gpio_mux_bank.sv
// Module: top of the GPIO bank. Decodes the register bus into set/clear
// strobes for six per-pin fields, drives the pad mux and returns status
// views and the synchronized pad levels on a combinational read port.
// Assumes one bus access per cycle and that read data is taken in the
// same cycle that the address is presented.
module gpio_mux_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pa_out,
    input  logic [NPINS-1:0]  pa_oe,
    input  logic [NPINS-1:0]  pb_out,
    input  logic [NPINS-1:0]  pb_oe,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu
);

    localparam int unsigned FLD_W = ADDR_W - 2;

    logic [FLD_W-1:0]                 acc_fld;
    cfg_port_e                        acc_port;
    logic [NUM_FIELDS-1:0][NPINS-1:0] cfg;
    logic [NPINS-1:0]                 level;

    // split the bus address into field and port
    always_comb begin
        acc_fld  = bus_addr[ADDR_W-1:2];
        acc_port = cfg_port_e'(bus_addr[1:0]);
    end

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        logic hit_set;
        logic hit_clr;

        // decode the set and clear strobes of this field
        always_comb begin
            hit_set = bus_we && (acc_fld == FLD_W'(f)) && (acc_port == PORT_SET);
            hit_clr = bus_we && (acc_fld == FLD_W'(f)) && (acc_port == PORT_CLR);
        end

        gpio_setclr_reg #(
            .WIDTH  (NPINS),
            .RST_BIT(field_reset_bit(f))
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .set_we(hit_set),
            .clr_we(hit_clr),
            .wmask (bus_wdata),
            .state (cfg[f])
        );
    end

    gpio_pad_mux #(
        .NPINS(NPINS)
    ) u_mux (
        .own    (cfg[FLD_OWN]),
        .bsel   (cfg[FLD_BSEL]),
        .gp_oe  (cfg[FLD_OE]),
        .gp_dout(cfg[FLD_DOUT]),
        .odrn   (cfg[FLD_ODRN]),
        .pa_out (pa_out),
        .pa_oe  (pa_oe),
        .pb_out (pb_out),
        .pb_oe  (pb_oe),
        .pad_out(pad_out),
        .pad_oe (pad_oe)
    );

    gpio_in_sync #(
        .WIDTH (NPINS),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (level)
    );

    // pull-up enables come straight from their field
    assign pad_pu = cfg[FLD_PULL];

    // read port: status views, level view, zero elsewhere
    always_comb begin
        bus_rdata = '0;
        if ((acc_port == PORT_STAT) && (acc_fld < FLD_W'(NUM_FIELDS))) begin
            bus_rdata = cfg[acc_fld];
        end else if ((acc_fld == FLD_W'(LEVEL_FIELD)) && (acc_port == PORT_SET)) begin
            bus_rdata = level;
        end
    end

    // R7
    odrn_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg[FLD_ODRN] & pad_oe & pad_out) == '0));

    // R5
    gpio_oe_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg[FLD_OWN] & ~cfg[FLD_ODRN] & (pad_oe ^ cfg[FLD_OE])) == '0));

    // R6
    perb_oe_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cfg[FLD_OWN] & ~cfg[FLD_ODRN] & cfg[FLD_BSEL] & (pad_oe ^ pb_oe)) == '0));

    // R6
    pera_out_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cfg[FLD_OWN] & ~cfg[FLD_ODRN] & ~cfg[FLD_BSEL] & (pad_out ^ pa_out)) == '0));

endmodule

// File: tb/gpio_mux_bank_tb.sv
// Bench: sweeps set/clear ports with walking masks, all pad-mux
// combinations, and pad level latency; expected values computed here.
module gpio_mux_bank_tb;

    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pad_pu;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_mux_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    function automatic logic [5:0] adr(input int fld, input int port);
        return 6'(fld * 4 + port);
    endfunction

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [NP-1:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    logic [NP-1:0] model [6];

    task automatic check_all_status(input string tag);
        logic [NP-1:0] v;
        for (int f = 0; f < 6; f++) begin
            rd(adr(f, 2), v);
            chk(tag, v, model[f]);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        model[0] = '1; model[1] = '0; model[2] = '0;
        model[3] = '0; model[4] = '1; model[5] = '0;
        check_all_status("R1 reset status");
        chk("R1 reset pad_oe", pad_oe, '0);
        chk("R1 reset pad_out", pad_out, '0);
        chk("R1 reset pad_pu", pad_pu, '1);

        // R2 / R3 walking one on every field
        for (int f = 0; f < 6; f++) begin
            for (int p = 0; p < NP; p++) begin
                wr(adr(f, 0), NP'(1) << p);
                model[f] = model[f] | (NP'(1) << p);
                rd(adr(f, 2), v);
                chk("R2 walking set", v, model[f]);
            end
            for (int p = 0; p < NP; p++) begin
                wr(adr(f, 1), NP'(1) << p);
                model[f] = model[f] & ~(NP'(1) << p);
                rd(adr(f, 2), v);
                chk("R3 walking clear", v, model[f]);
            end
            check_all_status("R2 R3 other fields kept");
        end

        // R2 / R3 with mixed masks, zeros preserved
        wr(adr(2, 0), 32'hF0F0_1234); model[2] |= 32'hF0F0_1234;
        wr(adr(2, 0), 32'h0000_8001); model[2] |= 32'h0000_8001;
        wr(adr(2, 1), 32'h3030_0004); model[2] &= ~32'h3030_0004;
        check_all_status("R3 mixed mask");

        // R4 set/clear ports read zero while state is nonzero
        for (int f = 0; f < 6; f++) begin
            rd(adr(f, 0), v); chk("R4 set reads 0", v, '0);
            rd(adr(f, 1), v); chk("R4 clr reads 0", v, '0);
        end

        // R8 pull-up follows field
        wr(adr(4, 0), 32'hA5A5_5A5A); model[4] |= 32'hA5A5_5A5A;
        wr(adr(4, 1), 32'h0F0F_00FF); model[4] &= ~32'h0F0F_00FF;
        @(negedge clk);
        chk("R8 pad_pu", pad_pu, model[4]);

        // R10 unmapped writes and reads
        for (int f = 0; f < 6; f++) wr(adr(f, 3), '1);
        wr(6'd28, '1); wr(6'd63, '1); wr(6'd25, '1);
        check_all_status("R10 unmapped write ignored");
        rd(6'd3, v);  chk("R10 unmapped read", v, '0);
        rd(6'd28, v); chk("R10 unmapped read", v, '0);
        rd(6'd63, v); chk("R10 unmapped read", v, '0);

        // R5 R6 R7 exhaustive mux sweep, same setting on all pins
        for (int c = 0; c < 512; c++) begin
            logic own, bs, oe, dt, od, ao, ae, bo, be, sd, se, eo, ee;
            {own, bs, oe, dt, od, ao, ae, bo, be} = 9'(c);
            wr(adr(0, own ? 0 : 1), '1);
            wr(adr(1, bs ? 0 : 1), '1);
            wr(adr(2, oe ? 0 : 1), '1);
            wr(adr(3, dt ? 0 : 1), '1);
            wr(adr(5, od ? 0 : 1), '1);
            pa_out = {NP{ao}}; pa_oe = {NP{ae}};
            pb_out = {NP{bo}}; pb_oe = {NP{be}};
            #0.5;
            if (own)     begin sd = dt; se = oe; end
            else if (bs) begin sd = bo; se = be; end
            else         begin sd = ao; se = ae; end
            if (od) begin eo = 1'b0; ee = se & ~sd; end
            else    begin eo = sd;   ee = se;       end
            if (od) begin
                chk("R7 open-drain pad_out", pad_out, {NP{eo}});
                chk("R7 open-drain pad_oe", pad_oe, {NP{ee}});
            end else if (own) begin
                chk("R5 gpio pad_out", pad_out, {NP{eo}});
                chk("R5 gpio pad_oe", pad_oe, {NP{ee}});
            end else begin
                chk("R6 periph pad_out", pad_out, {NP{eo}});
                chk("R6 periph pad_oe", pad_oe, {NP{ee}});
            end
        end

        // R6 per-pin select: even pins B, odd pins A, peripheral owned
        wr(adr(0, 1), '1); wr(adr(5, 1), '1);
        wr(adr(1, 1), '1); wr(adr(1, 0), 32'h5555_5555);
        pa_out = 32'hFFFF_0000; pa_oe = 32'hFF00_FF00;
        pb_out = 32'h0F0F_0F0F; pb_oe = 32'h3333_CCCC;
        #0.5;
        chk("R6 mixed select pad_out", pad_out,
            (32'h5555_5555 & 32'h0F0F_0F0F) | (32'hAAAA_AAAA & 32'hFFFF_0000));
        chk("R6 mixed select pad_oe", pad_oe,
            (32'h5555_5555 & 32'h3333_CCCC) | (32'hAAAA_AAAA & 32'hFF00_FF00));

        // R9 level latency, under peripheral then GPIO ownership
        for (int k = 0; k < 6; k++) begin
            logic [NP-1:0] old_v, new_v;
            if (k == 3) wr(adr(0, 0), '1);
            @(negedge clk);
            rd(6'd24, old_v);
            new_v = 32'h9E37_79B9 * (k + 1) ^ {16'(k), 16'hC3A5};
            pad_in = new_v;
            @(negedge clk);
            rd(6'd24, v); chk("R9 level after one edge", v, old_v);
            @(negedge clk);
            rd(6'd24, v); chk("R9 level after two edges", v, new_v);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule